// File: doc/BRIEF.md
# Gated Clock-Tick Counter Unit

This block keeps three 64-bit cycle counters that all run on one core clock but each obey their own gating rule. The non-halted counter is kept per logical processor. It advances only while that thread is neither halted nor power-saving. The non-sleep counter covers the whole physical processor. It advances only while nothing is asleep or power-saving. The time-stamp counter runs freely and stops only when the bus clock is gated, when the sleep pin is asserted or when the sleep level is deep. Because the gating rules differ, the time-stamp and non-sleep counts can legitimately disagree.

Software reads any counter through a registered read port. It can overwrite the performance counters, which are the two non-halted slots and the non-sleep counter. These counters wrap on overflow, record the event in sticky status bits and, if enabled, raise a one-cycle interrupt. The time-stamp counter cannot be written and never interrupts.

Top module: `tick_counter_unit`

## Requirements
- R1: After reset (active-low `rst_n`), every counter reads zero, `ovf_sts` and `irq` are zero and the interrupt enables are clear.
- R2: With `smt_en`=1, non-halted slot t (t=0,1) increments by one on each clock where `halt[t]`=0 and `psave[t]`=0; read it with `rd_sel`=0 and `rd_thr`=t.
- R3: With `smt_en`=0, only slot 0 counts, gated by thread 0. Slot 1 holds its value, and a read with `rd_sel`=0 returns slot 0 whatever `rd_thr` is.
- R4: The non-sleep counter (`rd_sel`=1) increments on each clock where `sleep_lvl`=0 and the package is not power-saving. The package is power-saving when both `psave` bits are set with `smt_en`=1, or when `psave[0]` is set with `smt_en`=0.
- R5: The time-stamp counter (`rd_sel`=2) increments on each clock where `bus_clk_act`=1, `sleep_pin`=0 and `sleep_lvl` < 2, independent of halt and power-save.
- R6: When `rd_en`=1, `rd_data` on the next clock holds the selected counter's value before that edge's update, and `rd_valid` is 1 for that one cycle. `rd_sel`=3 returns zero.
- R7: A performance counter that increments from all ones wraps to zero and sets its sticky bit in `ovf_sts`. Bit 0 is slot 0, bit 1 is slot 1 and bit 2 is non-sleep. The bit stays set until reset.
- R8: On that wrap, `irq` bit i pulses high for exactly one cycle if enable bit i was set before the edge. The enables are loaded from `ie_data` when `ie_we`=1.
- R9: `wr_en` loads `wr_data` into the counter chosen by `wr_sel`. Code 0 selects non-halted slot `wr_thr` and code 1 selects non-sleep. A write beats a same-cycle increment and cannot overflow. Codes 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smt_en | input | 1 | Two-thread mode |
| halt | input | 2 | Per-thread halted flag |
| psave | input | 2 | Per-thread power-save flag |
| sleep_lvl | input | 2 | 0 awake, 1 light, 2 deep, 3 deeper |
| bus_clk_act | input | 1 | Bus clock running |
| sleep_pin | input | 1 | Sleep pin asserted |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 2 | Write target code |
| wr_thr | input | 1 | Write thread slot |
| wr_data | input | CW | Write value |
| ie_we | input | 1 | Interrupt-enable write strobe |
| ie_data | input | 3 | New interrupt enables |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read counter code |
| rd_thr | input | 1 | Read thread slot |
| rd_data | output | CW | Read result |
| rd_valid | output | 1 | Read result valid |
| ovf_sts | output | 3 | Sticky overflow flags |
| irq | output | 3 | Overflow interrupt pulses |

## Verification
The hardest case to reach is a 64-bit counter wrapping, because counting up from reset would never get there. The stimulus writes values just below all ones into each performance counter. It does this both in directed sequences with every interrupt enabled and in random writes that are biased toward the top of the range. Random gating then decides whether and when each counter wraps. Some of those writes land on the same clock as an increment, so write priority and overflow are exercised together.

// File: rtl/tick_counter_unit.sv
module tick_counter_unit #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smt_en,
  input  logic [1:0]    halt,
  input  logic [1:0]    psave,
  input  logic [1:0]    sleep_lvl,
  input  logic          bus_clk_act,
  input  logic          sleep_pin,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic          wr_thr,
  input  logic [CW-1:0] wr_data,
  input  logic          ie_we,
  input  logic [2:0]    ie_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  input  logic          rd_thr,
  output logic [CW-1:0] rd_data,
  output logic          rd_valid,
  output logic [2:0]    ovf_sts,
  output logic [2:0]    irq
);
  logic [CW-1:0] nh0_q, nh1_q, ns_q, tsc_q;
  logic [2:0]    ie_q;
  logic [2:0]    inc, wsel, ovf;
  logic          tsc_inc, pkg_ps;

  assign pkg_ps  = smt_en ? &psave : psave[0];
  assign inc[0]  = !halt[0] && !psave[0];
  assign inc[1]  = smt_en && !halt[1] && !psave[1];
  assign inc[2]  = (sleep_lvl == 2'd0) && !pkg_ps;
  assign tsc_inc = bus_clk_act && !sleep_pin && !sleep_lvl[1];

  assign wsel[0] = wr_en && wr_sel == 2'd0 && !wr_thr;
  assign wsel[1] = wr_en && wr_sel == 2'd0 && wr_thr;
  assign wsel[2] = wr_en && wr_sel == 2'd1;

  assign ovf[0] = inc[0] && !wsel[0] && (&nh0_q);
  assign ovf[1] = inc[1] && !wsel[1] && (&nh1_q);
  assign ovf[2] = inc[2] && !wsel[2] && (&ns_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nh0_q <= '0;
      nh1_q <= '0;
      ns_q  <= '0;
      tsc_q <= '0;
    end else begin
      if (wsel[0])     nh0_q <= wr_data;
      else if (inc[0]) nh0_q <= nh0_q + 1'b1;
      if (wsel[1])     nh1_q <= wr_data;
      else if (inc[1]) nh1_q <= nh1_q + 1'b1;
      if (wsel[2])     ns_q  <= wr_data;
      else if (inc[2]) ns_q  <= ns_q + 1'b1;
      if (tsc_inc)     tsc_q <= tsc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= '0;
      ovf_sts <= '0;
      irq     <= '0;
    end else begin
      if (ie_we) ie_q <= ie_data;
      ovf_sts <= ovf_sts | ovf;
      irq     <= ovf & ie_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_sel)
          2'd0:    rd_data <= (smt_en && rd_thr) ? nh1_q : nh0_q;
          2'd1:    rd_data <= ns_q;
          2'd2:    rd_data <= tsc_q;
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

module tick_counter_unit_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smt_en,
  input logic [1:0]    sleep_lvl,
  input logic          bus_clk_act,
  input logic          sleep_pin,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          wr_thr,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [2:0]    ovf_sts,
  input logic [2:0]    irq,
  input logic [2:0]    ie_q,
  input logic [CW-1:0] nh1_q,
  input logic [CW-1:0] tsc_q
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sts[0] && ovf_sts[1] && ovf_sts[2] |=> &ovf_sts);
  a_r7_sts_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sts[0] |=> ovf_sts[0]);
  a_r8_irq_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> ovf_sts[0]);
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq[2] |=> !irq[2]);
  a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[1]) |-> $past(ie_q[1]));
  a_r5_tsc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_clk_act && !sleep_pin && sleep_lvl < 2'd2) |=> $stable(tsc_q));
  a_r3_slot1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !smt_en && !(wr_en && wr_sel == 2'd0 && wr_thr) |=> $stable(nh1_q));
endmodule

bind tick_counter_unit tick_counter_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smt_en(smt_en), .sleep_lvl(sleep_lvl),
  .bus_clk_act(bus_clk_act), .sleep_pin(sleep_pin), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_thr(wr_thr), .rd_en(rd_en), .rd_valid(rd_valid),
  .ovf_sts(ovf_sts), .irq(irq), .ie_q(ie_q), .nh1_q(nh1_q), .tsc_q(tsc_q)
);

// File: tb/tick_counter_unit_test.sv
module tick_counter_unit_test;
  localparam int CW = 64;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic smt_en = 0, bus_clk_act = 0, sleep_pin = 0, wr_en = 0, wr_thr = 0;
  logic ie_we = 0, rd_en = 0, rd_thr = 0;
  logic [1:0] halt = 0, psave = 0, sleep_lvl = 0, wr_sel = 0, rd_sel = 0;
  logic [2:0] ie_data = 0;
  logic [CW-1:0] wr_data = 0;
  logic [CW-1:0] rd_data;
  logic rd_valid;
  logic [2:0] ovf_sts, irq;

  int total = 0, bad = 0;
  logic [CW-1:0] m_nh0 = 0, m_nh1 = 0, m_ns = 0, m_tsc = 0, m_rd = 0;
  logic [2:0] m_ie = 0, m_sts = 0, m_irq = 0;
  logic m_rv = 0;
  string rd_tag = "R6";

  always #4 clk = ~clk;

  tick_counter_unit #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .smt_en(smt_en), .halt(halt), .psave(psave),
    .sleep_lvl(sleep_lvl), .bus_clk_act(bus_clk_act), .sleep_pin(sleep_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_thr(wr_thr), .wr_data(wr_data),
    .ie_we(ie_we), .ie_data(ie_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_thr(rd_thr), .rd_data(rd_data), .rd_valid(rd_valid),
    .ovf_sts(ovf_sts), .irq(irq)
  );

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] bump(logic [CW-1:0] v, logic w, logic i, output logic o);
    o = i && !w && (v == TOP);
    return w ? wr_data : (i ? v + 1'b1 : v);
  endfunction

  task automatic cyc();
    logic [2:0] inc, w, o;
    logic pps;
    logic [CW-1:0] n0, n1, ns, ts, rd;
    pps = smt_en ? &psave : psave[0];
    inc[0] = !halt[0] && !psave[0];
    inc[1] = smt_en && !halt[1] && !psave[1];
    inc[2] = sleep_lvl == 0 && !pps;
    w[0] = wr_en && wr_sel == 0 && !wr_thr;
    w[1] = wr_en && wr_sel == 0 && wr_thr;
    w[2] = wr_en && wr_sel == 1;
    n0 = bump(m_nh0, w[0], inc[0], o[0]);
    n1 = bump(m_nh1, w[1], inc[1], o[1]);
    ns = bump(m_ns, w[2], inc[2], o[2]);
    ts = (bus_clk_act && !sleep_pin && sleep_lvl < 2) ? m_tsc + 1'b1 : m_tsc;
    rd = m_rd;
    if (rd_en) begin
      case (rd_sel)
        2'd0: begin rd = (smt_en && rd_thr) ? m_nh1 : m_nh0; rd_tag = smt_en ? "R2" : "R3"; end
        2'd1: begin rd = m_ns; rd_tag = "R4"; end
        2'd2: begin rd = m_tsc; rd_tag = "R5"; end
        default: begin rd = 0; rd_tag = "R6"; end
      endcase
    end
    @(posedge clk);
    m_irq = o & m_ie;
    if (ie_we) m_ie = ie_data;
    m_sts = m_sts | o;
    m_nh0 = n0; m_nh1 = n1; m_ns = ns; m_tsc = ts; m_rd = rd; m_rv = rd_en;
    @(negedge clk);
    check("R7 ovf_sts", {61'd0, ovf_sts}, {61'd0, m_sts});
    check("R8 irq", {61'd0, irq}, {61'd0, m_irq});
    check("R6 rd_valid", {63'd0, rd_valid}, {63'd0, m_rv});
    if (m_rv) check(rd_tag, rd_data, m_rd);
  endtask

  task automatic idle_inputs();
    wr_en = 0; ie_we = 0; rd_en = 0;
  endtask

  task automatic read(logic [1:0] s, logic t);
    idle_inputs(); rd_en = 1; rd_sel = s; rd_thr = t; cyc();
  endtask

  initial begin
    #100000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    halt = 2'b11; psave = 2'b11; sleep_lvl = 2'd3;
    repeat (3) @(negedge clk);
    check("R1 ovf_sts", {61'd0, ovf_sts}, 0);
    check("R1 irq", {61'd0, irq}, 0);
    check("R1 rd_valid", {63'd0, rd_valid}, 0);
    rst_n = 1;
    for (int s = 0; s < 4; s++) read(s[1:0], 1'b0);

    // R9: write beats increment; codes 2 and 3 ignored
    smt_en = 1; halt = 0; psave = 0; sleep_lvl = 0; bus_clk_act = 1;
    idle_inputs(); wr_en = 1; wr_sel = 0; wr_thr = 0; wr_data = 64'd500; cyc();
    idle_inputs(); wr_en = 1; wr_sel = 2; wr_data = 64'd7; rd_en = 1; rd_sel = 0; cyc();
    check("R9 write won", m_rd, 64'd500);
    idle_inputs(); wr_en = 1; wr_sel = 3; rd_en = 1; rd_sel = 2; cyc();

    // R7 R8: directed wraps on all performance counters
    idle_inputs(); ie_we = 1; ie_data = 3'b111; cyc();
    idle_inputs(); wr_en = 1; wr_sel = 0; wr_thr = 0; wr_data = TOP - 1; cyc();
    idle_inputs(); wr_en = 1; wr_sel = 0; wr_thr = 1; wr_data = TOP - 1; cyc();
    idle_inputs(); wr_en = 1; wr_sel = 1; wr_data = TOP - 2; cyc();
    for (int i = 0; i < 4; i++) read(2'd0, i[0]);
    check("R7 all wrapped", {61'd0, ovf_sts}, 64'd7);
    idle_inputs(); ie_we = 1; ie_data = 0; cyc();

    // R3: single-thread mode
    smt_en = 0;
    for (int i = 0; i < 6; i++) read(2'd0, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      smt_en = ($urandom % 4) != 0;
      halt = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      psave = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      sleep_lvl = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      bus_clk_act = ($urandom % 8) != 0;
      sleep_pin = ($urandom % 8) == 0;
      rd_en = ($urandom % 4) != 0; rd_sel = 2'($urandom); rd_thr = 1'($urandom);
      wr_en = ($urandom % 10) == 0; wr_sel = 2'($urandom); wr_thr = 1'($urandom);
      wr_data = ($urandom % 2) ? TOP - 64'($urandom % 6) : {$urandom, $urandom};
      ie_we = ($urandom % 50) == 0; ie_data = 3'($urandom);
      cyc();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule